// File: doc/BRIEF.md
# Program-Counter Sequencer with Four-Entry Return Stack

This block keeps the program counter of a small word-addressed processor and owns its four-entry hardware return stack. The instruction decoder, which lives outside the block, raises one request strobe per executed instruction. The requests are:

- advance to the next word
- branch
- two-word call
- call through the accumulator
- return
- push of the accumulator
- pop to the accumulator
- enable interrupts
- disable interrupts
- a marker that a multiply was executed

The block answers with the new program counter, the value most recently taken off the stack, and the state of the interrupt mask.

The stack is a plain shifting register file with no pointer. A fifth push silently loses the oldest entry. A pop refills the vacated bottom place with its previous contents, so the bottom entry is duplicated. A level-sensitive interrupt line is latched into a pending flag. When the flag is set, the mask is clear, and the previous accepted request was neither a multiply nor an interrupt enable, the block enters the handler:

- it saves the current program counter on the same stack
- it jumps to a fixed vector
- it sets the mask

Entry occupies three cycles. During those cycles `irq_busy` is high and request strobes are ignored, so the decoder has to hold its fetch.

Top module: `seqr_top`

## Requirements
- R1: A lone advance request makes `pc_out` equal to the previous value plus one, wrapping to 0 from all-ones of the ADDR_W-bit width; a lone branch request loads `target_word` into `pc_out`.
- R2: A push request shifts every stack entry one place deeper, drops the deepest entry, writes the low ADDR_W bits of `acc_value` to the top and advances the PC by one; a fifth push without pops loses the first value pushed.
- R3: A call request pushes PC+2 (the word after the two-word call) and loads `target_word` into the PC.
- R4: A call-through-accumulator request pushes PC+1 and loads the low ADDR_W bits of `acc_value` into the PC.
- R5: A return request loads the top entry into both `pc_out` and `pop_value`; a pop request loads it into `pop_value` and advances the PC by one; both shift the entries toward the top while the deepest entry keeps its value, so after four pops a fifth returns the same value again.
- R6: Interrupt entry pushes the current PC, loads the PC with vector IRQ_VEC (default 2), and holds `irq_busy` high for exactly three consecutive cycles, during which every request strobe is ignored.
- R7: `int_mask` is set by interrupt entry and by a disable request, and is cleared by an enable request.
- R8: After reset `pc_out` is 0, `pop_value` is 0, `int_mask` is 1 and `irq_busy` is 0.
- R9: A high level on `irq_level` in any cycle sets a pending flag that persists while masked; no entry begins while the mask is set; once unmasked (and unblocked) the pending interrupt is entered; entry clears the flag.
- R10: In the cycle right after an accepted multiply or enable request no entry begins; entry becomes possible after the next accepted request of another kind.
- R11: When several strobes are high together only the highest-priority one acts, in order call, call-through-accumulator, return, branch, push, pop, enable, disable, multiply, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_call | input | 1 | Two-word call request |
| op_call_acc | input | 1 | Call through accumulator request |
| op_return | input | 1 | Return request |
| op_branch | input | 1 | Branch request |
| op_push | input | 1 | Push accumulator request |
| op_pop | input | 1 | Pop to accumulator request |
| op_int_enable | input | 1 | Clear interrupt mask |
| op_int_disable | input | 1 | Set interrupt mask |
| op_multiply | input | 1 | A multiply instruction executed (advances PC) |
| op_advance | input | 1 | Sequential advance |
| target_word | input | ADDR_W | Second instruction word holding a branch or call target |
| acc_value | input | ACC_W | Accumulator contents |
| irq_level | input | 1 | Maskable interrupt, level sensitive |
| pc_out | output | ADDR_W | Current program counter |
| pop_value | output | ADDR_W | Value taken by the last pop or return |
| irq_busy | output | 1 | High during the three interrupt-entry cycles |
| int_mask | output | 1 | Interrupt mask state |

## Verification
Stack behaviour is tried with five pushes followed by five pops using distinct values. This separates a correct drop-oldest shift and bottom duplication from pointer-style wraparound or zero refill. An accumulator value with high bits set shows masking to the address width. Calls from known addresses separate the two return offsets, +2 for the two-word call and +1 for the call through the accumulator. Interrupt sequences raise the line while masked, then unmask through an enable and through a multiply-then-advance path. This tells a latched level from an edge, shows the one-request block, and counts the busy cycles while strobes are presented and must be ignored.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int unsigned NUM_STROBES = 10;

    typedef enum logic [3:0] {
        OP_IDLE,
        OP_ADVANCE,
        OP_BRANCH,
        OP_CALL,
        OP_CALL_ACC,
        OP_RETURN,
        OP_PUSH,
        OP_POP,
        OP_INT_EN,
        OP_INT_DIS,
        OP_MULTIPLY
    } seq_op_e;

    // strobe index 0 has the highest priority
    function automatic seq_op_e strobe_to_op(input int unsigned idx);
        case (idx)
            0:       return OP_CALL;
            1:       return OP_CALL_ACC;
            2:       return OP_RETURN;
            3:       return OP_BRANCH;
            4:       return OP_PUSH;
            5:       return OP_POP;
            6:       return OP_INT_EN;
            7:       return OP_INT_DIS;
            8:       return OP_MULTIPLY;
            9:       return OP_ADVANCE;
            default: return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/seqr_op_select.sv
module seqr_op_select
    import seqr_pkg::*;
(
    input  logic [NUM_STROBES-1:0] strobes,
    output seq_op_e                op_sel
);

    always_comb begin
        op_sel = OP_IDLE;
        // walk from lowest to highest priority, last hit wins
        for (int i = NUM_STROBES - 1; i >= 0; i--) begin
            if (strobes[i]) begin
                op_sel = strobe_to_op(i);
            end
        end
    end

endmodule

// File: rtl/seqr_stack.sv
module seqr_stack #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] top_val
);

    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [WIDTH-1:0] ent_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == 0) begin : g_top
            always_comb begin
                if (push_en)     ent_d[g] = push_val;
                else if (pop_en) ent_d[g] = (DEPTH > 1) ? ent_q[(DEPTH > 1) ? 1 : 0] : ent_q[g];
                else             ent_d[g] = ent_q[g];
            end
        end else if (g == DEPTH - 1) begin : g_bottom
            // deepest entry keeps its value on a pop
            always_comb begin
                if (push_en) ent_d[g] = ent_q[g-1];
                else         ent_d[g] = ent_q[g];
            end
        end else begin : g_mid
            always_comb begin
                if (push_en)     ent_d[g] = ent_q[g-1];
                else if (pop_en) ent_d[g] = ent_q[g+1];
                else             ent_d[g] = ent_q[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign top_val = ent_q[0];

endmodule

// File: rtl/seqr_irq_ctrl.sv
module seqr_irq_ctrl
    import seqr_pkg::*;
#(
    parameter int unsigned ENTRY_CYCLES = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    irq_level,
    input  seq_op_e op_exec,     // accepted request, OP_IDLE if none
    output logic    take,
    output logic    busy,
    output logic    mask
);

    localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENTRY_CYCLES - 1);

    typedef struct packed {
        logic             pending;
        logic             mask;
        logic             block;
        logic [CNT_W-1:0] cnt;
    } irq_state_t;

    irq_state_t st_q, st_d;

    logic op_valid;
    logic op_blocks;

    assign op_valid  = (op_exec != OP_IDLE);
    assign op_blocks = (op_exec == OP_MULTIPLY) || (op_exec == OP_INT_EN);

    assign take = st_q.pending && !st_q.mask && !st_q.block && (st_q.cnt == '0);
    assign busy = take || (st_q.cnt != '0);
    assign mask = st_q.mask;

    always_comb begin
        st_d = st_q;
        st_d.pending = (st_q.pending || irq_level) && !take;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (take) begin
            st_d.mask  = 1'b1;
            st_d.cnt   = CNT_LOAD;
            st_d.block = 1'b0;
        end else if (op_valid) begin
            st_d.block = op_blocks;
            if (op_exec == OP_INT_EN)  st_d.mask = 1'b0;
            if (op_exec == OP_INT_DIS) st_d.mask = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pending <= 1'b0;
            st_q.mask    <= 1'b1;
            st_q.block   <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/seqr_top.sv
module seqr_top
    import seqr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned ACC_W        = 16,
    parameter int unsigned STACK_DEPTH  = 4,
    parameter int unsigned IRQ_VEC      = 2,
    parameter int unsigned ENTRY_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_call,
    input  logic              op_call_acc,
    input  logic              op_return,
    input  logic              op_branch,
    input  logic              op_push,
    input  logic              op_pop,
    input  logic              op_int_enable,
    input  logic              op_int_disable,
    input  logic              op_multiply,
    input  logic              op_advance,
    input  logic [ADDR_W-1:0] target_word,
    input  logic [ACC_W-1:0]  acc_value,
    input  logic              irq_level,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] pop_value,
    output logic              irq_busy,
    output logic              int_mask
);

    localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(IRQ_VEC);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] popv;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;

    logic [NUM_STROBES-1:0] strobes;
    seq_op_e                op_sel;
    seq_op_e                op_exec;
    logic                   take;
    logic                   busy;
    logic                   push_en;
    logic                   pop_en;
    logic [ADDR_W-1:0]      push_val;
    logic [ADDR_W-1:0]      stack_top;
    logic [ADDR_W-1:0]      acc_addr;
    logic [ADDR_W-1:0]      pc_plus1;
    logic [ADDR_W-1:0]      pc_plus2;

    assign strobes = {op_advance, op_multiply, op_int_disable, op_int_enable,
                      op_pop, op_push, op_branch, op_return, op_call_acc, op_call};

    if (ACC_W > ADDR_W) begin : g_acc_wide
        logic [ACC_W-ADDR_W-1:0] unused_acc_hi;
        assign unused_acc_hi = acc_value[ACC_W-1:ADDR_W];
        assign acc_addr      = acc_value[ADDR_W-1:0];
    end else begin : g_acc_narrow
        assign acc_addr = ADDR_W'(acc_value);
    end

    seqr_op_select u_sel (
        .strobes (strobes),
        .op_sel  (op_sel)
    );

    assign op_exec = busy ? OP_IDLE : op_sel;

    seqr_irq_ctrl #(
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_level (irq_level),
        .op_exec   (op_exec),
        .take      (take),
        .busy      (busy),
        .mask      (int_mask)
    );

    seqr_stack #(
        .WIDTH (ADDR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .push_val (push_val),
        .top_val  (stack_top)
    );

    assign pc_plus1 = cur_q.pc + ADDR_W'(1);
    assign pc_plus2 = cur_q.pc + ADDR_W'(2);

    always_comb begin
        nxt_d    = cur_q;
        push_en  = 1'b0;
        pop_en   = 1'b0;
        push_val = '0;
        if (take) begin
            push_en  = 1'b1;
            push_val = cur_q.pc;
            nxt_d.pc = VEC_ADDR;
        end else begin
            case (op_exec)
                OP_ADVANCE, OP_MULTIPLY, OP_INT_EN, OP_INT_DIS: begin
                    nxt_d.pc = pc_plus1;
                end
                OP_BRANCH: begin
                    nxt_d.pc = target_word;
                end
                OP_CALL: begin
                    push_en  = 1'b1;
                    push_val = pc_plus2;
                    nxt_d.pc = target_word;
                end
                OP_CALL_ACC: begin
                    push_en  = 1'b1;
                    push_val = pc_plus1;
                    nxt_d.pc = acc_addr;
                end
                OP_RETURN: begin
                    pop_en     = 1'b1;
                    nxt_d.pc   = stack_top;
                    nxt_d.popv = stack_top;
                end
                OP_PUSH: begin
                    push_en  = 1'b1;
                    push_val = acc_addr;
                    nxt_d.pc = pc_plus1;
                end
                OP_POP: begin
                    pop_en     = 1'b1;
                    nxt_d.popv = stack_top;
                    nxt_d.pc   = pc_plus1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc_out    = cur_q.pc;
    assign pop_value = cur_q.popv;
    assign irq_busy  = busy;

endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned IRQ_VEC      = 2,
    parameter int unsigned ENTRY_CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_call,
    input logic              op_call_acc,
    input logic              op_return,
    input logic              op_branch,
    input logic              op_push,
    input logic              op_pop,
    input logic              op_int_enable,
    input logic              op_int_disable,
    input logic              op_multiply,
    input logic              op_advance,
    input logic [ADDR_W-1:0] pc_out,
    input logic [ADDR_W-1:0] pop_value,
    input logic              irq_busy,
    input logic              int_mask
);

    localparam int unsigned RUN_W = $clog2(ENTRY_CYCLES + 2) + 1;

    logic [9:0]       stb;
    logic             single;
    logic [RUN_W-1:0] run_q;

    assign stb    = {op_advance, op_multiply, op_int_disable, op_int_enable,
                     op_pop, op_push, op_branch, op_return, op_call_acc, op_call};
    assign single = ($countones(stb) == 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (irq_busy) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R1: lone advance increments with wrap
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_busy && op_advance && single) |=> (pc_out == $past(pc_out) + ADDR_W'(1)));

    // R5: return loads the popped value into the PC
    a_r5_return_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_busy && op_return && single) |=> (pc_out == pop_value));

    // R6: entry jumps to the vector
    a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_busy) |=> (pc_out == ADDR_W'(IRQ_VEC)));

    // R6: busy lasts exactly ENTRY_CYCLES cycles
    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_busy) |-> (run_q == RUN_W'(ENTRY_CYCLES)));

    a_r6_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
        irq_busy |-> (run_q < RUN_W'(ENTRY_CYCLES)));

    // R6: strobes are ignored while busy after the entry cycle
    a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_busy && $past(irq_busy)) |=> $stable(pc_out));

    // R7: entry sets the mask
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_busy) |=> int_mask);

    // R9: no entry begins while masked
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask && !irq_busy) |=> !irq_busy);

endmodule

bind seqr_top seqr_checker #(
    .ADDR_W       (ADDR_W),
    .IRQ_VEC      (IRQ_VEC),
    .ENTRY_CYCLES (ENTRY_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_call        (op_call),
    .op_call_acc    (op_call_acc),
    .op_return      (op_return),
    .op_branch      (op_branch),
    .op_push        (op_push),
    .op_pop         (op_pop),
    .op_int_enable  (op_int_enable),
    .op_int_disable (op_int_disable),
    .op_multiply    (op_multiply),
    .op_advance     (op_advance),
    .pc_out         (pc_out),
    .pop_value      (pop_value),
    .irq_busy       (irq_busy),
    .int_mask       (int_mask)
);

// File: tb/seqr_top_tb.sv
module seqr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;

    localparam int B_CALL  = 0;
    localparam int B_CALLA = 1;
    localparam int B_RET   = 2;
    localparam int B_BR    = 3;
    localparam int B_PUSH  = 4;
    localparam int B_POP   = 5;
    localparam int B_EN    = 6;
    localparam int B_DIS   = 7;
    localparam int B_MUL   = 8;
    localparam int B_ADV   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    stb = '0;
    logic [AW-1:0] target = '0;
    logic [DW-1:0] acc = '0;
    logic          irq = 1'b0;
    logic [AW-1:0] pc_out;
    logic [AW-1:0] pop_value;
    logic          irq_busy;
    logic          int_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqr_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_call        (stb[B_CALL]),
        .op_call_acc    (stb[B_CALLA]),
        .op_return      (stb[B_RET]),
        .op_branch      (stb[B_BR]),
        .op_push        (stb[B_PUSH]),
        .op_pop         (stb[B_POP]),
        .op_int_enable  (stb[B_EN]),
        .op_int_disable (stb[B_DIS]),
        .op_multiply    (stb[B_MUL]),
        .op_advance     (stb[B_ADV]),
        .target_word    (target),
        .acc_value      (acc),
        .irq_level      (irq),
        .pc_out         (pc_out),
        .pop_value      (pop_value),
        .irq_busy       (irq_busy),
        .int_mask       (int_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; presents strobes for one rising edge, returns at the next falling edge
    task automatic do_op(input logic [9:0] mask, input logic [AW-1:0] tgt, input logic [DW-1:0] a);
        stb    = mask;
        target = tgt;
        acc    = a;
        @(negedge clk);
        stb = '0;
    endtask

    function automatic logic [9:0] one(input int b);
        return 10'(1) << b;
    endfunction

    task automatic t_reset();
        chk("R8 pc", 32'(pc_out), 32'h0);
        chk("R8 pop", 32'(pop_value), 32'h0);
        chk("R8 mask", 32'(int_mask), 32'h1);
        chk("R8 busy", 32'(irq_busy), 32'h0);
    endtask

    task automatic t_advance_wrap();
        do_op(one(B_BR), 12'hFFE, '0);
        chk("R1 branch", 32'(pc_out), 32'hFFE);
        do_op(one(B_ADV), '0, '0);
        chk("R1 advance", 32'(pc_out), 32'hFFF);
        do_op(one(B_ADV), '0, '0);
        chk("R1 wrap", 32'(pc_out), 32'h000);
    endtask

    task automatic t_call_ret();
        do_op(one(B_BR), 12'h005, '0);
        do_op(one(B_CALL), 12'h100, '0);
        chk("R3 call target", 32'(pc_out), 32'h100);
        do_op(one(B_RET), '0, '0);
        chk("R3 return address", 32'(pc_out), 32'h007);
        chk("R5 return pop", 32'(pop_value), 32'h007);
    endtask

    task automatic t_call_acc();
        do_op(one(B_BR), 12'h020, '0);
        do_op(one(B_CALLA), '0, 16'hF234);
        chk("R4 acc target", 32'(pc_out), 32'h234);
        do_op(one(B_RET), '0, '0);
        chk("R4 return address", 32'(pc_out), 32'h021);
    endtask

    task automatic t_stack_depth();
        logic [AW-1:0] exp_pops [5];
        exp_pops = '{12'h555, 12'h444, 12'h333, 12'h222, 12'h222};
        do_op(one(B_BR), 12'h200, '0);
        do_op(one(B_PUSH), '0, 16'h0111);
        do_op(one(B_PUSH), '0, 16'h0222);
        do_op(one(B_PUSH), '0, 16'h0333);
        do_op(one(B_PUSH), '0, 16'h0444);
        do_op(one(B_PUSH), '0, 16'h0555);
        chk("R2 push advances", 32'(pc_out), 32'h205);
        for (int i = 0; i < 5; i++) begin
            do_op(one(B_POP), '0, '0);
            chk("R5 R2 pop order", 32'(pop_value), 32'(exp_pops[i]));
        end
        chk("R5 pop advances", 32'(pc_out), 32'h20A);
        do_op(one(B_PUSH), '0, 16'hABCD);
        do_op(one(B_POP), '0, '0);
        chk("R2 push masked", 32'(pop_value), 32'hBCD);
    endtask

    task automatic t_priority();
        do_op(one(B_BR), 12'h010, '0);
        do_op(one(B_CALL) | one(B_ADV) | one(B_PUSH), 12'h300, 16'h0777);
        chk("R11 call wins", 32'(pc_out), 32'h300);
        do_op(one(B_RET), '0, '0);
        chk("R11 only call acted", 32'(pc_out), 32'h012);
    endtask

    task automatic t_irq_masked_then_enabled();
        do_op(one(B_BR), 12'h040, '0);
        irq = 1'b1;
        do_op(one(B_ADV), '0, '0);
        irq = 1'b0;
        chk("R9 masked no entry", 32'(irq_busy), 32'h0);
        do_op(one(B_ADV), '0, '0);
        chk("R9 still masked", 32'(irq_busy), 32'h0);
        chk("R9 pc advancing", 32'(pc_out), 32'h042);
        do_op(one(B_EN), '0, '0);
        chk("R7 enable clears mask", 32'(int_mask), 32'h0);
        chk("R10 blocked after enable", 32'(irq_busy), 32'h0);
        do_op(one(B_ADV), '0, '0);
        chk("R9 pending taken", 32'(irq_busy), 32'h1);
        chk("R9 pc before entry", 32'(pc_out), 32'h044);
        do_op(one(B_ADV), '0, '0);
        chk("R6 busy 2", 32'(irq_busy), 32'h1);
        chk("R6 vector", 32'(pc_out), 32'h002);
        do_op(one(B_BR), 12'h3AA, '0);
        chk("R6 busy 3", 32'(irq_busy), 32'h1);
        do_op(one(B_ADV), '0, '0);
        chk("R6 busy ends", 32'(irq_busy), 32'h0);
        chk("R6 strobes ignored", 32'(pc_out), 32'h002);
        chk("R7 entry sets mask", 32'(int_mask), 32'h1);
        do_op(one(B_RET), '0, '0);
        chk("R6 saved pc", 32'(pc_out), 32'h044);
    endtask

    task automatic t_irq_after_mul();
        do_op(one(B_BR), 12'h080, '0);
        do_op(one(B_EN), '0, '0);
        irq = 1'b1;
        do_op(one(B_MUL), '0, '0);
        irq = 1'b0;
        chk("R10 blocked after multiply", 32'(irq_busy), 32'h0);
        chk("R10 multiply advances", 32'(pc_out), 32'h082);
        do_op(one(B_ADV), '0, '0);
        chk("R10 taken after next", 32'(irq_busy), 32'h1);
        repeat (3) do_op(one(B_ADV), '0, '0);
        chk("R6 vector again", 32'(pc_out), 32'h002);
        do_op(one(B_RET), '0, '0);
        chk("R6 saved pc after multiply", 32'(pc_out), 32'h083);
        do_op(one(B_EN), '0, '0);
        do_op(one(B_DIS), '0, '0);
        chk("R7 disable sets mask", 32'(int_mask), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_advance_wrap();
        t_call_ret();
        t_call_acc();
        t_stack_depth();
        t_priority();
        t_irq_masked_then_enabled();
        t_irq_after_mul();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule